// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory out of power-up after reset. When it receives a start pulse, it walks through a fixed list of device commands, one after another. The list is: two NOPs that turn on the memory clock and raise the clock enable, two precharge-all commands, writes to extended mode registers 2, 3 and 1, a mode register write that resets the DLL, two auto-refreshes, the final mode register write, and an OCD default/exit pair. At the end it reports that the memory is in normal mode.

Each command is presented for exactly one clock on a command interface as a code, a bank address and a row address. Between commands the interface carries NOP. The controller sets the length of each wait as a cycle count. There is one count for the long power-up waits, one for the short mode-register waits, one for DLL lock and one for refresh recovery. The CAS latency and an OCD option are also supplied as configuration. The block takes a copy of every configuration value at start. After it reaches normal mode it enables the periodic refresh timer of the surrounding controller.

Top module: `ddr2_init_seq`

## Requirements
- R1: A synchronous active-low reset returns the block to idle within one clock. While in idle, cmd_valid=0, cmd_code=0 (NOP), cmd_ba=0, cmd_addr=0, ck_en=0, cke=0, done=0 and refresh_en=0. This holds even if the reset comes in the middle of a sequence.
- R2: In idle, the block begins a sequence when a rising edge samples start high. The first command strobe is driven from the following rising edge.
- R3: The command order is fixed and uses this code encoding: NOP=0, PRE=1, MRS=2, EMRS=3, REF=4. The order is: NOP, NOP, PRE, EMRS (BA[1:0]=2), EMRS (BA=3), EMRS (BA=1), MRS (BA=0), PRE, REF, REF, MRS (BA=0), EMRS (BA=1, OCD default), EMRS (BA=1, OCD exit).
- R4: cmd_valid is high for exactly one clock per command. While cmd_valid is low, cmd_code, cmd_ba and cmd_addr are all zero.
- R5: Each command has a wait count W. The block sends exactly max(W,1) idle clocks after the command, so the next strobe comes max(W,1)+1 clocks later. W is cfg_wait_pwr after the second NOP and after the first PRE, cfg_wait_dll after EMRS BA=1 with DLL enable, and cfg_wait_rfc after each REF. Every other command uses cfg_wait_mrd.
- R6: An MRS carries these fields: cmd_addr[2:0]=BL_CODE (default 3'b010), cmd_addr[6:4]=CAS latency, cmd_addr[8]=DLL reset and cmd_addr[11:9]=WR_CODE (default 3'b001). All other bits are 0. The first MRS has DLL reset set to 1; the second has it set to 0.
- R7: For EMRS commands, cmd_ba[1:0] selects the target register, and the upper bits of cmd_ba are 0. EMRS2, EMRS3 and the DLL-enable EMRS1 carry cmd_addr=0. The OCD-default EMRS1 carries cmd_addr[9:7]=3'b111 and 0 elsewhere. The OCD-exit EMRS1 carries cmd_addr=0.
- R8: When cfg_ocd_skip=1, the OCD-default EMRS1 is left out and the sequence has 12 commands instead of 13. The wait after the second MRS still leads to the OCD-exit EMRS1.
- R9: ck_en goes high together with the first NOP strobe, and cke goes high together with the second. Both stay high until reset. No command other than NOP is issued while cke is low.
- R10: done goes high max(cfg_wait_mrd,1) clocks after the last strobe and stays high. refresh_en goes high one clock after done and stays high. No strobe is issued once done is high.
- R11: A start pulse while a sequence is running, or after done, has no effect on the commands, their timing or done.
- R12: The configuration is copied when start is accepted. Changing any cfg input during a sequence has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start pulse, acted on only in idle |
| cfg_cas | input | 3 | CAS latency written into the MRS |
| cfg_ocd_skip | input | 1 | 1 omits the OCD-default EMRS1 |
| cfg_wait_pwr | input | CNT_W | Wait count for the power-up steps |
| cfg_wait_mrd | input | CNT_W | Wait count for the mode-register steps |
| cfg_wait_dll | input | CNT_W | Wait count for DLL lock |
| cfg_wait_rfc | input | CNT_W | Wait count after each refresh |
| cmd_valid | output | 1 | One-clock command strobe |
| cmd_code | output | 3 | Command code |
| cmd_ba | output | BA_W | Bank address |
| cmd_addr | output | ADDR_W | Row address / mode value |
| ck_en | output | 1 | Memory clock enable |
| cke | output | 1 | Memory clock-enable pin level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Normal mode reached |
| refresh_en | output | 1 | Periodic refresh timer enable |

## Verification
The assertions assume that reset is applied before the first start and that cfg_cas lies within the MRS field. They place no limit on the timing of start or on changes to the cfg inputs. The bench applies reset first and uses CAS latencies of 3 and 4 only. Its random runs vary every wait count, including zero, and in some runs they toggle start and change every cfg input while the sequence runs, to exercise the rule that such changes are ignored.

// File: rtl/ddr2_init_pkg.sv
// Package: shared command codes, state encoding and step numbers for the
// DDR2 power-up sequencer.
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_MRS  = 3'd2,
        CMD_EMRS = 3'd3,
        CMD_REF  = 3'd4
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    localparam int unsigned NUM_STEPS = 13;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    localparam logic [STEP_W-1:0] STEP_CLK_NOP = STEP_W'(0);
    localparam logic [STEP_W-1:0] STEP_CKE_NOP = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_OCD_DEF = STEP_W'(11);
    localparam logic [STEP_W-1:0] STEP_LAST    = STEP_W'(NUM_STEPS - 1);

endpackage

// File: rtl/ddr2_init_wait.sv
// Module: loadable down-counter that times the gap after each command.
// Assumes: load is high for one clock at command issue. expire is high
// once the count reaches one or zero, so a count of 0 acts like 1.
module ddr2_init_wait #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on issue, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Purpose: flag the last idle clock of the gap.
    always_comb begin
        expire = (cnt_q <= CNT_W'(1));
    end
endmodule

// File: rtl/ddr2_init_step.sv
// Module: combinational decode of a step number into a command code, a
// bank address, an address/mode value and a wait count.
// Assumes: step is below NUM_STEPS and ADDR_W is at least 12.
module ddr2_init_step
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W  = 14,
    parameter int unsigned BA_W    = 3,
    parameter int unsigned CNT_W   = 16,
    parameter logic [2:0]  BL_CODE = 3'b010,
    parameter logic [2:0]  WR_CODE = 3'b001
) (
    input  logic [STEP_W-1:0] step,
    input  logic [2:0]        cas,
    input  logic [CNT_W-1:0]  wait_pwr,
    input  logic [CNT_W-1:0]  wait_mrd,
    input  logic [CNT_W-1:0]  wait_dll,
    input  logic [CNT_W-1:0]  wait_rfc,
    output ddr_cmd_e          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  wait_cycles
);
    localparam int unsigned OCD_LSB = 7;
    localparam int unsigned DLL_RST = 8;

    // Purpose: build the MRS operating value with or without DLL reset.
    function automatic logic [ADDR_W-1:0] mrs_word(input logic [2:0] lat,
                                                   input logic dll_rst);
        logic [ADDR_W-1:0] w;
        w          = '0;
        w[2:0]     = BL_CODE;
        w[6:4]     = lat;
        w[DLL_RST] = dll_rst;
        w[11:9]    = WR_CODE;
        return w;
    endfunction

    // Purpose: build the EMRS1 value carrying the OCD default code.
    function automatic logic [ADDR_W-1:0] ocd_word();
        logic [ADDR_W-1:0] w;
        w                      = '0;
        w[OCD_LSB+2:OCD_LSB]   = 3'b111;
        return w;
    endfunction

    // Purpose: map each step to its command, target register and wait.
    always_comb begin
        cmd         = CMD_NOP;
        ba          = '0;
        addr        = '0;
        wait_cycles = wait_mrd;
        case (step)
            STEP_W'(0):  cmd = CMD_NOP;
            STEP_W'(1):  begin cmd = CMD_NOP; wait_cycles = wait_pwr; end
            STEP_W'(2):  begin cmd = CMD_PRE; wait_cycles = wait_pwr; end
            STEP_W'(3):  begin cmd = CMD_EMRS; ba[1:0] = 2'b10; end
            STEP_W'(4):  begin cmd = CMD_EMRS; ba[1:0] = 2'b11; end
            STEP_W'(5):  begin cmd = CMD_EMRS; ba[1:0] = 2'b01; wait_cycles = wait_dll; end
            STEP_W'(6):  begin cmd = CMD_MRS; addr = mrs_word(cas, 1'b1); end
            STEP_W'(7):  cmd = CMD_PRE;
            STEP_W'(8):  begin cmd = CMD_REF; wait_cycles = wait_rfc; end
            STEP_W'(9):  begin cmd = CMD_REF; wait_cycles = wait_rfc; end
            STEP_W'(10): begin cmd = CMD_MRS; addr = mrs_word(cas, 1'b0); end
            STEP_W'(11): begin cmd = CMD_EMRS; ba[1:0] = 2'b01; addr = ocd_word(); end
            STEP_W'(12): begin cmd = CMD_EMRS; ba[1:0] = 2'b01; end
            default:     cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// Module: DDR2 power-up sequencer top. It accepts start in idle, copies
// the configuration, issues the fixed command list with programmed gaps,
// then holds done and enables refresh.
// Assumes: rst_n is applied before the first start. A restart needs reset.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ADDR_W  = 14,
    parameter int unsigned BA_W    = 3,
    parameter int unsigned CNT_W   = 16,
    parameter logic [2:0]  BL_CODE = 3'b010,
    parameter logic [2:0]  WR_CODE = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg_cas,
    input  logic              cfg_ocd_skip,
    input  logic [CNT_W-1:0]  cfg_wait_pwr,
    input  logic [CNT_W-1:0]  cfg_wait_mrd,
    input  logic [CNT_W-1:0]  cfg_wait_dll,
    input  logic [CNT_W-1:0]  cfg_wait_rfc,
    output logic              cmd_valid,
    output logic [2:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              ck_en,
    output logic              cke,
    output logic              busy,
    output logic              done,
    output logic              refresh_en
);
    seq_state_e        state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nxt;
    logic [2:0]        cas_q;
    logic              ocd_skip_q;
    logic [CNT_W-1:0]  wpwr_q, wmrd_q, wdll_q, wrfc_q;

    ddr_cmd_e          dec_cmd;
    logic [BA_W-1:0]   dec_ba;
    logic [ADDR_W-1:0] dec_addr;
    logic [CNT_W-1:0]  dec_wait;
    logic              gap_over;

    ddr2_init_step #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .BL_CODE(BL_CODE), .WR_CODE(WR_CODE)
    ) u_step (
        .step(step_q), .cas(cas_q),
        .wait_pwr(wpwr_q), .wait_mrd(wmrd_q),
        .wait_dll(wdll_q), .wait_rfc(wrfc_q),
        .cmd(dec_cmd), .ba(dec_ba), .addr(dec_addr),
        .wait_cycles(dec_wait)
    );

    ddr2_init_wait #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .load(state_q == ST_ISSUE),
        .load_val(dec_wait),
        .expire(gap_over)
    );

    // Purpose: choose the next step, skipping the OCD default if asked.
    always_comb begin
        step_nxt = step_q + STEP_W'(1);
        if (ocd_skip_q && (step_nxt == STEP_OCD_DEF)) begin
            step_nxt = step_nxt + STEP_W'(1);
        end
    end

    // Purpose: sequencer state, configuration copy and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            cas_q      <= '0;
            ocd_skip_q <= 1'b0;
            wpwr_q     <= '0;
            wmrd_q     <= '0;
            wdll_q     <= '0;
            wrfc_q     <= '0;
            cmd_valid  <= 1'b0;
            cmd_code   <= CMD_NOP;
            cmd_ba     <= '0;
            cmd_addr   <= '0;
            ck_en      <= 1'b0;
            cke        <= 1'b0;
            done       <= 1'b0;
            refresh_en <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cas_q      <= cfg_cas;
                        ocd_skip_q <= cfg_ocd_skip;
                        wpwr_q     <= cfg_wait_pwr;
                        wmrd_q     <= cfg_wait_mrd;
                        wdll_q     <= cfg_wait_dll;
                        wrfc_q     <= cfg_wait_rfc;
                        step_q     <= '0;
                        state_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    cmd_valid <= 1'b1;
                    cmd_code  <= dec_cmd;
                    cmd_ba    <= dec_ba;
                    cmd_addr  <= dec_addr;
                    if (step_q == STEP_CLK_NOP) ck_en <= 1'b1;
                    if (step_q == STEP_CKE_NOP) cke   <= 1'b1;
                    state_q   <= ST_WAIT;
                end
                ST_WAIT: begin
                    cmd_valid <= 1'b0;
                    cmd_code  <= CMD_NOP;
                    cmd_ba    <= '0;
                    cmd_addr  <= '0;
                    if (gap_over) begin
                        if (step_q == STEP_LAST) begin
                            done    <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            step_q  <= step_nxt;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: begin
                    refresh_en <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: report an active sequence.
    always_comb begin
        busy = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    end
endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Module: property checker for the DDR2 power-up sequencer, bound to the top.
// Assumes: reset is applied before any start.
module ddr2_init_seq_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BA_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_code,
    input logic [BA_W-1:0]   cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              ck_en,
    input logic              cke,
    input logic              done,
    input logic              refresh_en
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && cmd_code == 3'd0 && !cke && !ck_en && !done && !refresh_en)); // R1
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R4
    AST_NOP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_code == 3'd0 && cmd_ba == '0 && cmd_addr == '0)); // R4
    AST_MRS_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd2) |-> cmd_ba == '0); // R6
    AST_EMRS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd3) |-> cmd_ba[1:0] != 2'b00); // R7
    AST_CKE_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code != 3'd0) |-> (cke && ck_en)); // R9
    AST_CKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke); // R9
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R10
    AST_NO_CMD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R10
    AST_REFRESH_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_en |-> done); // R10
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .ck_en(ck_en), .cke(cke),
    .done(done), .refresh_en(refresh_en)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 14;
    localparam int BA_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg_cas = 3'd3;
    logic cfg_ocd_skip = 1'b0;
    logic [CNT_W-1:0] cfg_wait_pwr = '0, cfg_wait_mrd = '0, cfg_wait_dll = '0, cfg_wait_rfc = '0;
    logic cmd_valid, ck_en, cke, busy, done, refresh_en;
    logic [2:0] cmd_code;
    logic [BA_W-1:0] cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;

    int tests = 0;
    int fails = 0;
    int cycle = 0;
    int nlog = 0;
    int done_cyc = -1;
    int ref_cyc = -1;
    bit log_en = 1'b0;
    int lg_cmd[32], lg_ba[32], lg_addr[32], lg_cyc[32], lg_cke[32], lg_cken[32];

    ddr2_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_cas(cfg_cas),
        .cfg_ocd_skip(cfg_ocd_skip), .cfg_wait_pwr(cfg_wait_pwr),
        .cfg_wait_mrd(cfg_wait_mrd), .cfg_wait_dll(cfg_wait_dll),
        .cfg_wait_rfc(cfg_wait_rfc), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .ck_en(ck_en), .cke(cke),
        .busy(busy), .done(done), .refresh_en(refresh_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    // Strobe recorder: command, bank, address and cycle stamp.
    always @(negedge clk) begin
        if (log_en) begin
            if (cmd_valid && nlog < 32) begin
                lg_cmd[nlog] = int'(cmd_code);
                lg_ba[nlog] = int'(cmd_ba);
                lg_addr[nlog] = int'(cmd_addr);
                lg_cyc[nlog] = cycle;
                lg_cke[nlog] = int'(cke);
                lg_cken[nlog] = int'(ck_en);
                nlog = nlog + 1;
            end
            if (done && done_cyc < 0) done_cyc = cycle;
            if (refresh_en && ref_cyc < 0) ref_cyc = cycle;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected values from the requirements.
    function automatic int exp_cmd(input int s);
        case (s)
            0, 1: return 0;
            2, 7: return 1;
            6, 10: return 2;
            8, 9: return 4;
            default: return 3;
        endcase
    endfunction

    function automatic int exp_ba(input int s);
        case (s)
            3: return 2;
            4: return 3;
            5, 11, 12: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_addr(input int s, input int cas);
        case (s)
            6: return 2 | (cas << 4) | (1 << 8) | (1 << 9);
            10: return 2 | (cas << 4) | (1 << 9);
            11: return 7 << 7;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_gap(input int s, input int pwr, input int mrd,
                                   input int dll, input int rfc);
        int w;
        case (s)
            1, 2: w = pwr;
            5: w = dll;
            8, 9: w = rfc;
            default: w = mrd;
        endcase
        return (w < 1) ? 1 : w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!cmd_valid && cmd_code == 0 && cmd_ba == 0 && cmd_addr == 0, "R1", "cmd idle after reset", int'(cmd_code), 0);
        check(!ck_en && !cke && !done && !refresh_en && !busy, "R1", "flags low after reset",
              int'({ck_en, cke, done, refresh_en, busy}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_seq(input int cas, input bit skip, input int pwr, input int mrd,
                           input int dll, input int rfc, input bit disturb);
        int s, n, ec, guard, bad, n_before;
        int es[13];
        @(negedge clk);
        cfg_cas = 3'(cas); cfg_ocd_skip = skip;
        cfg_wait_pwr = CNT_W'(pwr); cfg_wait_mrd = CNT_W'(mrd);
        cfg_wait_dll = CNT_W'(dll); cfg_wait_rfc = CNT_W'(rfc);
        nlog = 0; done_cyc = -1; ref_cyc = -1; log_en = 1'b1;
        s = cycle;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 6000) begin
            @(negedge clk);
            guard++;
            if (disturb) begin
                start = 1'($urandom % 2);
                cfg_cas = 3'($urandom); cfg_ocd_skip = 1'($urandom);
                cfg_wait_pwr = CNT_W'($urandom % 500); cfg_wait_mrd = CNT_W'($urandom % 500);
                cfg_wait_dll = CNT_W'($urandom % 500); cfg_wait_rfc = CNT_W'($urandom % 500);
            end
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        n = 0;
        for (int k = 0; k < 13; k++) begin
            if (!(skip && k == 11)) begin es[n] = k; n++; end
        end
        bad = 0;
        check(nlog == n, skip ? "R8" : "R3", "strobe count", nlog, n);
        if (nlog != n) bad++;
        ec = s + 2;
        for (int i = 0; i < n && i < nlog; i++) begin
            if (i == 0) check(lg_cyc[0] == ec, "R2", "first strobe cycle", lg_cyc[0], ec);
            else check(lg_cyc[i] == ec, "R5", "strobe spacing", lg_cyc[i], ec);
            check(lg_cmd[i] == exp_cmd(es[i]), "R3", "command order", lg_cmd[i], exp_cmd(es[i]));
            check(lg_ba[i] == exp_ba(es[i]), "R7", "bank address", lg_ba[i], exp_ba(es[i]));
            check(lg_addr[i] == exp_addr(es[i], cas), (exp_cmd(es[i]) == 2) ? "R6" : "R7",
                  "address value", lg_addr[i], exp_addr(es[i], cas));
            check(lg_cken[i] == 1 && lg_cke[i] == ((i == 0) ? 0 : 1), "R9", "clock enables",
                  lg_cken[i] * 2 + lg_cke[i], (i == 0) ? 2 : 3);
            if (lg_cyc[i] != ec || lg_cmd[i] != exp_cmd(es[i]) || lg_addr[i] != exp_addr(es[i], cas)) bad++;
            ec = lg_cyc[i] + exp_gap(es[i], pwr, mrd, dll, rfc) + 1;
        end
        check(done_cyc == ec - 1, "R10", "done cycle", done_cyc, ec - 1);
        check(ref_cyc == ec, "R10", "refresh_en cycle", ref_cyc, ec);
        if (disturb) begin
            check(bad == 0, "R11", "start pulses while busy ignored", bad, 0);
            check(bad == 0, "R12", "cfg changes while busy ignored", bad, 0);
        end
        n_before = nlog;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(nlog == n_before && done && !busy, "R11", "start after done ignored", nlog, n_before);
        log_en = 1'b0;
        do_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        run_seq(4, 1'b0, 40, 2, 200, 18, 1'b0);
        run_seq(3, 1'b1, 40, 2, 200, 18, 1'b0);
        run_seq(3, 1'b0, 0, 0, 0, 1, 1'b0);
        run_seq(4, 1'b0, 60, 3, 210, 14, 1'b1);
        // Reset in the middle of a sequence.
        @(negedge clk);
        cfg_wait_pwr = 16'd100; cfg_wait_mrd = 16'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cmd_valid && cmd_code == 0 && !cke && !ck_en && !busy && !done, "R1",
              "mid-sequence reset", int'({cmd_valid, cke, ck_en, busy}), 0);
        rst_n = 1'b1;
        for (int r = 0; r < 12; r++) begin
            run_seq(($urandom % 2) ? 4 : 3, 1'($urandom), int'($urandom % 80), int'($urandom % 8),
                    int'($urandom % 260), int'($urandom % 30), (r % 3) == 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule